// File: doc/BRIEF.md
# Multichannel Configuration Latch Bank

This block is the write-only control register file of a four-channel serial transceiver. Software, or a sequencer, loads it through a narrow port: a 4-bit address, an 8-bit data byte and a write strobe. Each channel owns three byte-wide latches. The receive-static latch sets framer mode, framing character, decoder mode, decoder bypass, receive clock select and receive rate. The transmit-static latch holds the transmit-side selections. The dynamic latch holds the power, test, output-enable and buffer-reset controls. The latched bytes are driven out in parallel, one byte per channel and per latch kind, and the surrounding datapath decodes them.

Three addresses above the channel range broadcast a write to one latch kind in every channel. A channel takes part only if that latch's own enable bit is set, or if the written byte carries a force bit. A mask register restricts which bits any dynamic write may change. The phase-align buffer reset is turned into a one-cycle pulse rather than a level. One receive-side reconfiguration is forbidden until the next full reset. The block detects it and raises a sticky per-channel error flag.

Top module: `cfg_latch_bank`

## Requirements
- R1: While `rst` is high at a rising edge, every channel's receive-static latch becomes 0xBF, transmit-static 0xAD and dynamic 0xB3. The mask becomes 0xFF. All pulse and error outputs become 0.
- R2: The latch of kind t in channel c sits at address 3c+t, where t=0 is receive-static, t=1 is transmit-static and t=2 is dynamic. A direct write to a static latch stores the full byte, including bit 0, and the new value shows on the output after that edge.
- R3: Addresses 12, 13 and 14 broadcast to latch kind 0, 1 and 2 of every channel. A channel's latch accepts the broadcast when its stored bit 0 (global enable) is 1 or the written bit 0 (force) is 1. It then takes written bits 7..1 and keeps its own bit 0.
- R4: A broadcast without force leaves unchanged every latch whose stored bit 0 is 0.
- R5: Address 15 writes the mask. A dynamic write, direct or broadcast, changes only the bits where the mask is 1. Static writes ignore the mask.
- R6: Bit 1 of the dynamic latch is the phase-align buffer reset. When a dynamic write leaves that bit 0, `pab_rst_o` for the channel is high for exactly the one cycle after the write edge. The stored and output bit 1 reads 1 afterwards.
- R7: In the receive-static latch, bit 3 is decoder bypass, bit 2 is receive clock select and bit 1 is receive rate. If a channel's bits 3..1 are all 0 and a write (direct or broadcast) sets bits 3 and 2 to 1, `reconfig_err_o` for that channel goes high after the edge and stays high. The write is still applied.
- R8: Reset clears every error flag.
- R9: With `wr_en` low, no latch or the mask changes, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes occur on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Latch address |
| wr_data | input | 8 | Write data |
| rx_cfg_o | output | 32 | Receive-static latches, channel c at bits 8c+7..8c |
| tx_cfg_o | output | 32 | Transmit-static latches, same packing |
| dyn_cfg_o | output | 32 | Dynamic latches, same packing |
| pab_rst_o | output | 4 | Per-channel phase-align buffer reset pulse |
| reconfig_err_o | output | 4 | Per-channel sticky forbidden-reconfiguration flag |

## Verification
Every latch is registered directly onto an output. A wrong decode, a missed global-enable gate or a mask slip therefore shows on the parallel buses one edge after the offending write, and the bench compares all buses after every write. A wrong pulse or error register shows on the same cycle. A pulse that lingers shows on the following idle cycle. The sweep covers every address with a scrambled set of data bytes. Gating and mask states therefore keep changing, and any divergence surfaces on the next compare.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
  localparam int DW = 8;
  typedef logic [DW-1:0] cfg_byte_t;

  localparam cfg_byte_t RX_RST   = 8'hBF;
  localparam cfg_byte_t TX_RST   = 8'hAD;
  localparam cfg_byte_t DYN_RST  = 8'hB3;
  localparam cfg_byte_t MASK_RST = 8'hFF;

  localparam int GE_BIT    = 0;
  localparam int PAB_BIT   = 1;
  localparam int RATE_BIT  = 1;
  localparam int CKSEL_BIT = 2;
  localparam int BYP_BIT   = 3;

  typedef enum int {KIND_RX = 0, KIND_TX = 1, KIND_DYN = 2} latch_kind_e;
  localparam int NKIND = 3;

  // merge candidate into old value under a bit mask
  function automatic cfg_byte_t mask_merge(cfg_byte_t old_v, cfg_byte_t cand, cfg_byte_t m);
    return (old_v & ~m) | (cand & m);
  endfunction

  // broadcast value: upper bits from data, own enable bit kept
  function automatic cfg_byte_t global_cand(cfg_byte_t old_v, cfg_byte_t d);
    return {d[DW-1:1], old_v[GE_BIT]};
  endfunction

  function automatic logic global_take(cfg_byte_t old_v, cfg_byte_t d);
    return old_v[GE_BIT] | d[GE_BIT];
  endfunction

  // forbidden receive reconfiguration
  function automatic logic bad_reconfig(cfg_byte_t old_v, cfg_byte_t new_v);
    return (old_v[BYP_BIT:RATE_BIT] == 3'b000) && new_v[BYP_BIT] && new_v[CKSEL_BIT];
  endfunction
endpackage

// File: rtl/cfg_addr_dec.sv
module cfg_addr_dec
  import cfg_bank_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  output logic [NKIND*NCH-1:0] dir_we,
  output logic [NKIND-1:0]     glb_we,
  output logic                 mask_we
);
  localparam int NLAT      = NKIND * NCH;
  localparam int GLB_BASE  = NLAT;
  localparam int MASK_ADDR = NLAT + NKIND;

  always_comb begin
    for (int k = 0; k < NLAT; k++)
      dir_we[k] = wr_en && (int'(wr_addr) == k);
    for (int t = 0; t < NKIND; t++)
      glb_we[t] = wr_en && (int'(wr_addr) == GLB_BASE + t);
    mask_we = wr_en && (int'(wr_addr) == MASK_ADDR);
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dir_we, glb_we, mask_we})); // R2
  AST_IDLE_NO_TARGET: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> ({dir_we, glb_we, mask_we} == '0)); // R9
endmodule

// File: rtl/cfg_latch.sv
module cfg_latch
  import cfg_bank_pkg::*;
#(
  parameter cfg_byte_t RST_VAL  = 8'h00,
  parameter bit        HOLD_PAB = 1'b0
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      dir_we,
  input  logic      glb_we,
  input  cfg_byte_t wdata,
  input  cfg_byte_t mask,
  output cfg_byte_t q,
  output logic      upd,
  output cfg_byte_t nxt
);
  logic      take_glb;
  cfg_byte_t cand;
  cfg_byte_t stored;

  always_comb begin
    take_glb = glb_we && global_take(q, wdata);
    upd      = dir_we || take_glb;
    cand     = dir_we ? wdata : global_cand(q, wdata);
    nxt      = mask_merge(q, cand, mask);
    stored   = nxt;
    if (HOLD_PAB) stored[PAB_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)      q <= RST_VAL;
    else if (upd) q <= stored;
  end

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(q)); // R9
  AST_GLOBAL_KEEPS_GE: assert property (@(posedge clk) disable iff (rst)
    (glb_we && !dir_we) |=> (q[GE_BIT] == $past(q[GE_BIT]))); // R3
  AST_MASK_FREEZE: assert property (@(posedge clk) disable iff (rst)
    upd |=> (((q ^ $past(q)) & ~$past(mask) & 8'hFD) == 8'h00)); // R5
endmodule

// File: rtl/cfg_chan.sv
module cfg_chan
  import cfg_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NKIND-1:0] dir_we,
  input  logic [NKIND-1:0] glb_we,
  input  cfg_byte_t        wdata,
  input  cfg_byte_t        mask,
  output cfg_byte_t        rx_q,
  output cfg_byte_t        tx_q,
  output cfg_byte_t        dyn_q,
  output logic             pab_pulse,
  output logic             err
);
  logic      rx_upd, tx_upd, dyn_upd;
  cfg_byte_t rx_nxt, tx_nxt, dyn_nxt;
  logic      pab_fire;
  logic      bad_hit;

  cfg_latch #(.RST_VAL(RX_RST), .HOLD_PAB(1'b0)) u_rx (
    .clk(clk), .rst(rst), .dir_we(dir_we[KIND_RX]), .glb_we(glb_we[KIND_RX]),
    .wdata(wdata), .mask(8'hFF), .q(rx_q), .upd(rx_upd), .nxt(rx_nxt));

  cfg_latch #(.RST_VAL(TX_RST), .HOLD_PAB(1'b0)) u_tx (
    .clk(clk), .rst(rst), .dir_we(dir_we[KIND_TX]), .glb_we(glb_we[KIND_TX]),
    .wdata(wdata), .mask(8'hFF), .q(tx_q), .upd(tx_upd), .nxt(tx_nxt));

  cfg_latch #(.RST_VAL(DYN_RST), .HOLD_PAB(1'b1)) u_dyn (
    .clk(clk), .rst(rst), .dir_we(dir_we[KIND_DYN]), .glb_we(glb_we[KIND_DYN]),
    .wdata(wdata), .mask(mask), .q(dyn_q), .upd(dyn_upd), .nxt(dyn_nxt));

  always_comb begin
    pab_fire = dyn_upd && !dyn_nxt[PAB_BIT];
    bad_hit  = rx_upd && bad_reconfig(rx_q, rx_nxt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pab_pulse <= 1'b0;
      err       <= 1'b0;
    end else begin
      pab_pulse <= pab_fire;
      if (bad_hit) err <= 1'b1;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err |=> err); // R7
  AST_PAB_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    pab_pulse |-> $past(dyn_upd)); // R6
  AST_PAB_STORED_HIGH: assert property (@(posedge clk) disable iff (rst)
    dyn_upd |=> dyn_q[PAB_BIT]); // R6
  AST_ERR_NEEDS_RX_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> $past(rx_upd)); // R7
  AST_TX_UNUSED_NXT: assert property (@(posedge clk) disable iff (rst)
    tx_upd |=> (tx_q == $past(tx_nxt))); // R2
endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank
  import cfg_bank_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = $clog2(NKIND * NCH + NKIND + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [NCH*DW-1:0] rx_cfg_o,
  output logic [NCH*DW-1:0] tx_cfg_o,
  output logic [NCH*DW-1:0] dyn_cfg_o,
  output logic [NCH-1:0]    pab_rst_o,
  output logic [NCH-1:0]    reconfig_err_o
);
  localparam int NLAT = NKIND * NCH;

  logic [NLAT-1:0]  dir_we;
  logic [NKIND-1:0] glb_we;
  logic             mask_we;
  cfg_byte_t        mask_q;

  cfg_addr_dec #(.NCH(NCH), .AW(AW)) u_dec (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .dir_we(dir_we), .glb_we(glb_we), .mask_we(mask_we));

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= MASK_RST;
    else if (mask_we) mask_q <= wr_data;
  end

  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (rst)
    !mask_we |=> $stable(mask_q)); // R5

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    cfg_byte_t rx_b, tx_b, dyn_b;
    cfg_chan u_ch (
      .clk(clk), .rst(rst),
      .dir_we(dir_we[NKIND*c +: NKIND]), .glb_we(glb_we),
      .wdata(wr_data), .mask(mask_q),
      .rx_q(rx_b), .tx_q(tx_b), .dyn_q(dyn_b),
      .pab_pulse(pab_rst_o[c]), .err(reconfig_err_o[c]));
    assign rx_cfg_o[DW*c +: DW]  = rx_b;
    assign tx_cfg_o[DW*c +: DW]  = tx_b;
    assign dyn_cfg_o[DW*c +: DW] = dyn_b;
  end

  AST_ERR_RESET: assert property (@(posedge clk)
    rst |=> (reconfig_err_o == '0)); // R8
endmodule

// File: tb/tb_cfg_latch_bank.sv
module tb_cfg_latch_bank;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [31:0] rx_cfg_o, tx_cfg_o, dyn_cfg_o;
  logic [3:0]  pab_rst_o, reconfig_err_o;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] m_rx[NCH], m_tx[NCH], m_dyn[NCH];
  logic [7:0] m_mask;
  logic [3:0] m_err, m_pab;

  always #2.5 clk = ~clk;

  cfg_latch_bank dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rx_cfg_o(rx_cfg_o), .tx_cfg_o(tx_cfg_o), .dyn_cfg_o(dyn_cfg_o),
    .pab_rst_o(pab_rst_o), .reconfig_err_o(reconfig_err_o));

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin
      m_rx[c] = 8'hBF; m_tx[c] = 8'hAD; m_dyn[c] = 8'hB3;
    end
    m_mask = 8'hFF; m_err = '0; m_pab = '0;
  endtask

  task automatic apply(input int c, input int t, input logic [7:0] d, input bit direct);
    logic [7:0] old_v, cand, n;
    old_v = (t == 0) ? m_rx[c] : (t == 1) ? m_tx[c] : m_dyn[c];
    if (!direct && old_v[0] == 1'b0 && d[0] == 1'b0) return;
    cand = direct ? d : {d[7:1], old_v[0]};
    if (t == 2) begin
      n = (old_v & ~m_mask) | (cand & m_mask);
      if (n[1] == 1'b0) m_pab[c] = 1'b1;
      n[1] = 1'b1;
      m_dyn[c] = n;
    end else if (t == 1) begin
      m_tx[c] = cand;
    end else begin
      if (old_v[3:1] == 3'b000 && cand[3] && cand[2]) m_err[c] = 1'b1;
      m_rx[c] = cand;
    end
  endtask

  task automatic model_write(input logic [3:0] a, input logic [7:0] d);
    m_pab = '0;
    if (a < 12) apply(int'(a) / 3, int'(a) % 3, d, 1'b1);
    else if (a < 15) for (int c = 0; c < NCH; c++) apply(c, int'(a) - 12, d, 1'b0);
    else m_mask = d;
  endtask

  task automatic compare_all(input string tag);
    logic [31:0] erx, etx, edyn;
    for (int c = 0; c < NCH; c++) begin
      erx[8*c +: 8] = m_rx[c]; etx[8*c +: 8] = m_tx[c]; edyn[8*c +: 8] = m_dyn[c];
    end
    check(tag, "rx_cfg", rx_cfg_o, erx);
    check(tag, "tx_cfg", tx_cfg_o, etx);
    check(tag, "dyn_cfg", dyn_cfg_o, edyn);
    check(tag, "pab_rst", {28'h0, pab_rst_o}, {28'h0, m_pab});
    check(tag, "reconfig_err", {28'h0, reconfig_err_o}, {28'h0, m_err});
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d, input string tag);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    model_write(a, d);
    @(negedge clk);
    wr_en = 1'b0;
    compare_all(tag);
  endtask

  task automatic idle(input string tag);
    m_pab = '0;
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
    compare_all("R1/R8");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk);
    do_reset();                                    // R1

    wr(4'd0, 8'h30, "R2");                         // ch0 rx: bits3..1 = 000, ge = 0
    wr(4'd4, 8'h5A, "R2");                         // ch1 tx direct
    wr(4'd12, 8'h0E, "R3/R4");                     // ch0 skipped, others take 0x0F
    wr(4'd0, 8'h0C, "R7");                         // forbidden change on ch0
    idle("R7");
    wr(4'd15, 8'h0F, "R5");                        // mask low nibble
    wr(4'd2, 8'h00, "R5/R6");                      // ch0 dyn -> B0, pulse, stores B2
    idle("R6");                                    // pulse gone
    wr(4'd1, 8'h00, "R5");                         // static ignores mask
    wr(4'd13, 8'h00, "R4");                        // ch0 tx ge=0 not touched
    wr(4'd14, 8'h01, "R3/R6");                     // forced broadcast to dyn

    wr_en = 1'b0; wr_addr = 4'd3; wr_data = 8'h00;  // strobe low, no change
    idle("R9");
    wr_addr = 4'd15; idle("R9");

    do_reset();                                    // R8: error cleared

    for (int i = 0; i < 4096; i++) begin
      logic [3:0] a;
      logic [7:0] d;
      a = 4'(i * 7 + (i >> 4));
      d = 8'((i >> 4) * 37 + (i & 15) * 11);
      wr(a, d, "R2/R3/R5/R6/R7");
    end
    idle("R6");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule